// File: doc/BRIEF.md
# One-Hot Residue to Pulse-Count Converter

This block turns a modulo-5 residue, supplied as a serial one-hot bit stream, into a burst of shift-enable pulses for a rotating residue adder. Time is divided into ten-cycle frames by two complementary phase signals. A ten-stage circular register starts with five neighbouring ones, and two of its taps give the two phases. In the first half of each frame, the load phase, the enable is high on every cycle so that an operand can be shifted into the adder's ring. In the second half, the add phase, the enable carries on only until the hot bit of the residue arrives. The residue reaches this point through a fixed four-cycle delay line. A frame therefore holds exactly 5 + Y enable pulses.

The residue Y is sent one bit per cycle. The bit is high in the cycle whose index, counted from cycle 1 of the frame, equals Y, and low in every other cycle. After the delay, slot j of the add phase (frame cycle 5 + j) carries the bit for Y = j. The enable is high in each add slot that comes before the first hot bit.

Top module: `onehot_pulse_conv`

## Requirements
- R1: Reset loads the phase ring with exactly five adjacent ones. The cycle after reset is frame cycle 0, where ph_load = 1, ph_add = 0 and shift_en = 1.
- R2: ph_add is the complement of ph_load on every cycle.
- R3: ph_load is high in frame cycles 0 to 4 and low in frame cycles 5 to 9, repeating every ten cycles. The ring always holds five ones.
- R4: y_in is delayed by exactly four cycles. The level on y_in in frame cycle 1 + j governs add slot j, which is frame cycle 5 + j.
- R5: shift_en is high on every cycle of the load phase.
- R6: In add slot j, shift_en is high if and only if no hot bit has been seen in slots 0 to j. Y = 0 gives no add-phase pulse.
- R7: Each frame holds exactly 5 + Y shift_en pulses, for Y from 0 to 4.
- R8: Within one add phase, any hot bit after the first has no effect. The pulse count follows the first hot bit only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| y_in | input | 1 | Serial one-hot residue bit |
| shift_en | output | 1 | Shift-enable pulse to the rotating adder |
| ph_load | output | 1 | Load-phase signal (five high, five low) |
| ph_add | output | 1 | Add-phase signal, complement of ph_load |

## Verification
The assertions assume that y_in stays low during reset. They also assume that y_in carries at most one meaningful hot bit per frame, aligned to frame cycles 1 to 5. The stimulus drives y_in only at the falling clock edge. It raises y_in only in that five-cycle window, and picks the random residues from 0 to 4. A few directed frames add a second hot bit after the first, to exercise the ignore rule.

// File: rtl/onehot_pulse_conv_pkg.sv
package onehot_pulse_conv_pkg;
  localparam int unsigned RESIDUE_MOD = 5;
  localparam int unsigned Y_DELAY     = 4;

  // Number of enable pulses expected in one frame for residue y.
  function automatic int unsigned frame_pulses(input int unsigned modv, input int unsigned y);
    return modv + y;
  endfunction
endpackage

// File: rtl/conv_phase_ring.sv
module conv_phase_ring #(
  parameter int unsigned MODV = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [2*MODV-1:0] ring,
  output logic              ph_load,
  output logic              ph_add
);
  localparam int unsigned RW = 2 * MODV;

  function automatic logic [RW-1:0] ring_init();
    logic [RW-1:0] v;
    v = '0;
    for (int i = 0; i < int'(MODV); i++) v[i] = 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring <= ring_init();
    else        ring <= {ring[RW-2:0], ring[RW-1]};
  end

  assign ph_load = ring[MODV-1];
  assign ph_add  = ring[RW-1];
endmodule

// File: rtl/conv_delay_line.sv
module conv_delay_line #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] stage;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= 1'b0;
          else        stage[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= 1'b0;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/conv_pulse_gate.sv
module conv_pulse_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_load,
  input  logic ph_add,
  input  logic y_slot,
  output logic shift_en,
  output logic seen,
  output logic slot_hit
);
  assign slot_hit = ph_add & y_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen <= 1'b0;
    else if (ph_load)  seen <= 1'b0;
    else if (slot_hit) seen <= 1'b1;
  end

  assign shift_en = ph_load | (ph_add & ~seen & ~y_slot);
endmodule

// File: rtl/onehot_pulse_conv.sv
module onehot_pulse_conv
  import onehot_pulse_conv_pkg::*;
#(
  parameter int unsigned MODV  = RESIDUE_MOD,
  parameter int unsigned DELAY = Y_DELAY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic y_in,
  output logic shift_en,
  output logic ph_load,
  output logic ph_add
);
  localparam int unsigned RW = 2 * MODV;

  logic [RW-1:0] ring_q;
  logic          y_slot;
  logic          seen_q;
  logic          slot_hit;

  conv_phase_ring #(.MODV(MODV)) u_ring (
    .clk(clk), .rst_n(rst_n), .ring(ring_q), .ph_load(ph_load), .ph_add(ph_add)
  );

  conv_delay_line #(.DEPTH(DELAY)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(y_in), .dout(y_slot)
  );

  conv_pulse_gate u_gate (
    .clk(clk), .rst_n(rst_n), .ph_load(ph_load), .ph_add(ph_add),
    .y_slot(y_slot), .shift_en(shift_en), .seen(seen_q), .slot_hit(slot_hit)
  );
endmodule

// File: rtl/onehot_pulse_conv_chk.sv
module onehot_pulse_conv_chk #(
  parameter int unsigned MODV = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*MODV-1:0] ring_q,
  input logic              ph_load,
  input logic              ph_add,
  input logic              shift_en,
  input logic              seen_q,
  input logic              slot_hit
);
  p_phase_compl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_load != ph_add);

  p_ring_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring_q) == MODV);

  p_ring_contig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring_q ^ {ring_q[2*MODV-2:0], ring_q[2*MODV-1]}) == 2);

  p_load_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ph_load |-> shift_en);

  p_hit_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_hit |-> !shift_en);

  p_after_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_add && seen_q) |-> !shift_en);

  p_seen_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ph_load |=> (!seen_q));
endmodule

bind onehot_pulse_conv onehot_pulse_conv_chk #(.MODV(MODV)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_q(ring_q), .ph_load(ph_load), .ph_add(ph_add),
  .shift_en(shift_en), .seen_q(seen_q), .slot_hit(slot_hit)
);

// File: tb/onehot_pulse_conv_tb.sv
module onehot_pulse_conv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MODV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic y_in = 1'b0;
  logic shift_en, ph_load, ph_add;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  onehot_pulse_conv u_dut (
    .clk(clk), .rst_n(rst_n), .y_in(y_in),
    .shift_en(shift_en), .ph_load(ph_load), .ph_add(ph_add)
  );

  function automatic int exp_total(input int y);
    return y + MODV;
  endfunction

  function automatic bit exp_add_en(input int slot, input int y);
    return slot < y;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One frame; second hot bit at y2 (y2 > 4 means none). Called at a falling edge in frame cycle 0.
  task automatic run_frame(input int y, input int y2);
    int cnt;
    cnt = 0;
    for (int k = 0; k < 2*MODV; k++) begin
      check(ph_load == (k < MODV), "R3 ph_load", int'(ph_load), int'(k < MODV));
      check(ph_add == !ph_load, "R2 ph_add", int'(ph_add), int'(!ph_load));
      if (k < MODV) check(shift_en == 1'b1, "R5 load enable", int'(shift_en), 1);
      else check(shift_en == exp_add_en(k - MODV, y), "R4 R6 add slot",
                 int'(shift_en), int'(exp_add_en(k - MODV, y)));
      if (shift_en) cnt++;
      y_in = (k >= 1 && k <= MODV) && ((k - 1 == y) || (k - 1 == y2));
      @(negedge clk);
    end
    if (y2 < MODV) check(cnt == exp_total(y), "R8 extra hot bit ignored", cnt, exp_total(y));
    else           check(cnt == exp_total(y), "R7 frame count", cnt, exp_total(y));
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(ph_load == 1'b1 && ph_add == 1'b0 && shift_en == 1'b1, "R1 reset state",
          {ph_load, ph_add, shift_en}, 3'b101);
    rst_n = 1'b1;
    check(ph_load == 1'b1 && shift_en == 1'b1, "R1 frame cycle 0", {ph_load, shift_en}, 2'b11);
    // first frame: delay line still empty, drive Y for the frame itself
    for (int y = 0; y < MODV; y++) run_frame(y, 9);
    run_frame(1, 3);
    run_frame(0, 4);
    run_frame(2, 4);
    for (int y = MODV - 1; y >= 0; y--) run_frame(y, 9);
    for (int i = 0; i < 40; i++) run_frame(int'($urandom_range(MODV - 1, 0)), 9);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule